// File: doc/BRIEF.md
# Stack Pointer Unit with Push-History Record

This block owns the 8-bit stack pointer of a small processor whose stack lives in a 256-byte data memory. Each cycle it takes a push, pop or direct pointer load from the core. For a push or pop it produces a registered address and a write or read strobe toward the data memory. The pointer always names the most recently filled byte. A push therefore stores at the pointer plus one and then advances the pointer. A pop reads at the pointer and then steps it back. Pointer arithmetic wraps around the 256-byte space, so the stack may start at any address and may use all of it.

Beside the pointer, the block keeps a 32-bit history register that debug logic can read in parallel at any time. The requester supplies one tag bit with each push, for example 1 for a return address and 0 for plain data. That bit enters the low end of the history. A pop shifts the history back the other way, so after a pop the history shows the push before it again. A debugger can use the history to tell call frames from data in the live stack. A direct pointer load moves the pointer only and leaves the history alone. The memory array, interrupt sequencing and the debug transport sit outside this block.

Top module: `stack_pointer_unit`

## Requirements
- R1: In the cycle after reset is sampled high, the pointer reads 0x07, the history is all zeros, and both memory strobes are low. The first push after reset therefore stores to 0x08.
- R2: A push request with no load request makes the next cycle show: write strobe high, address equal to the old pointer plus one, write data equal to the pushed byte, and pointer equal to the old pointer plus one.
- R3: A pop request with no push and no load request makes the next cycle show: read strobe high, address equal to the old pointer, and pointer equal to the old pointer minus one.
- R4: Pointer arithmetic wraps modulo 256. A push at 0xFF writes to 0x00 and leaves the pointer at 0x00. A pop at 0x00 reads 0x00 and leaves the pointer at 0xFF.
- R5: A performed push shifts the history left by one. The push tag enters bit 0, and the old bit 31 is discarded.
- R6: A performed pop shifts the history right by one. Bit 0 is discarded, and bit 31 becomes 0.
- R7: A load request has priority over push and pop. The next cycle shows the pointer equal to the load value, the history unchanged, and both strobes low.
- R8: When push and pop are requested together without a load, only the push is performed.
- R9: With no request, the next cycle shows both strobes low and the pointer and history unchanged.
- R10: The write strobe and the read strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push request |
| push_data | input | 8 | Byte to push |
| push_tag | input | 1 | History bit recorded with the push |
| pop_req | input | 1 | Pop request |
| sp_load | input | 1 | Direct pointer load request |
| sp_load_val | input | 8 | New pointer value |
| sp_value | output | 8 | Current pointer |
| mem_addr | output | 8 | Registered data-memory address |
| mem_wdata | output | 8 | Registered write data |
| mem_we | output | 1 | Write strobe, one cycle per push |
| mem_re | output | 1 | Read strobe, one cycle per pop |
| dbg_history | output | 32 | Push-history register for debug |

## Verification
A corrupted pointer shows on `sp_value` in the cycle after the faulty operation. It also misdirects the next memory address by the same amount. Because the bench compares every cycle, the fault is found within one cycle. A history register that shifts the wrong way, or moves on a load, differs from the reference model on `dbg_history` in that same cycle. A wrong priority between load, push and pop shows as a spurious or missing strobe one cycle after the request.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2,
    STK_LOAD = 2'd3
  } stk_op_e;
endpackage

// File: rtl/stk_op_arbiter.sv
module stk_op_arbiter
  import stk_pkg::*;
(
  input  logic    push_req,
  input  logic    pop_req,
  input  logic    load_req,
  output stk_op_e op
);
  // load beats push, push beats pop
  always_comb begin
    if (load_req)      op = STK_LOAD;
    else if (push_req) op = STK_PUSH;
    else if (pop_req)  op = STK_POP;
    else               op = STK_IDLE;
  end
endmodule

// File: rtl/stk_pointer.sv
module stk_pointer
  import stk_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]    RESET_SP = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  stk_op_e           op,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] sp_q,
  output logic [ADDR_W-1:0] push_addr,
  output logic [ADDR_W-1:0] pop_addr
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  assign push_addr = sp_q + ONE;
  assign pop_addr  = sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= RESET_SP;
    end else begin
      case (op)
        STK_PUSH: sp_q <= push_addr;
        STK_POP:  sp_q <= sp_q - ONE;
        STK_LOAD: sp_q <= load_val;
        default:  sp_q <= sp_q;
      endcase
    end
  end
endmodule

// File: rtl/stk_history.sv
module stk_history
  import stk_pkg::*;
#(
  parameter int unsigned REC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  stk_op_e          op,
  input  logic             tag,
  output logic [REC_W-1:0] rec_q
);
  logic [REC_W-1:0] rec_d;

  for (genvar i = 0; i < REC_W; i++) begin : g_bit
    logic from_below;
    logic from_above;
    if (i == 0) begin : g_lo
      assign from_below = tag;
    end else begin : g_mid_lo
      assign from_below = rec_q[i-1];
    end
    if (i == REC_W - 1) begin : g_hi
      assign from_above = 1'b0;
    end else begin : g_mid_hi
      assign from_above = rec_q[i+1];
    end
    always_comb begin
      case (op)
        STK_PUSH: rec_d[i] = from_below;
        STK_POP:  rec_d[i] = from_above;
        default:  rec_d[i] = rec_q[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rec_q <= '0;
    else     rec_q <= rec_d;
  end
endmodule

// File: rtl/stk_mem_port.sv
module stk_mem_port
  import stk_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  stk_op_e           op,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [ADDR_W-1:0] pop_addr,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              we_q,
  output logic              re_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      we_q <= (op == STK_PUSH);
      re_q <= (op == STK_POP);
      if (op == STK_PUSH) begin
        addr_q  <= push_addr;
        wdata_q <= wdata_in;
      end else if (op == STK_POP) begin
        addr_q <= pop_addr;
      end
    end
  end
endmodule

// File: rtl/stack_pointer_unit.sv
module stack_pointer_unit
  import stk_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter int unsigned       DATA_W   = 8,
  parameter int unsigned       REC_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_SP = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_tag,
  input  logic              pop_req,
  input  logic              sp_load,
  input  logic [ADDR_W-1:0] sp_load_val,
  output logic [ADDR_W-1:0] sp_value,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [REC_W-1:0]  dbg_history
);
  stk_op_e           op;
  logic [ADDR_W-1:0] push_addr;
  logic [ADDR_W-1:0] pop_addr;

  stk_op_arbiter u_arb (
    .push_req (push_req),
    .pop_req  (pop_req),
    .load_req (sp_load),
    .op       (op)
  );

  stk_pointer #(.ADDR_W(ADDR_W), .RESET_SP(RESET_SP)) u_sp (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .load_val  (sp_load_val),
    .sp_q      (sp_value),
    .push_addr (push_addr),
    .pop_addr  (pop_addr)
  );

  stk_history #(.REC_W(REC_W)) u_hist (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .tag   (push_tag),
    .rec_q (dbg_history)
  );

  stk_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .push_addr (push_addr),
    .pop_addr  (pop_addr),
    .wdata_in  (push_data),
    .addr_q    (mem_addr),
    .wdata_q   (mem_wdata),
    .we_q      (mem_we),
    .re_q      (mem_re)
  );
endmodule

// File: rtl/stack_pointer_unit_checker.sv
module stack_pointer_unit_checker #(
  parameter int unsigned       ADDR_W   = 8,
  parameter int unsigned       DATA_W   = 8,
  parameter int unsigned       REC_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_SP = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              push_req,
  input logic [DATA_W-1:0] push_data,
  input logic              push_tag,
  input logic              pop_req,
  input logic              sp_load,
  input logic [ADDR_W-1:0] sp_load_val,
  input logic [ADDR_W-1:0] sp_value,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic              mem_re,
  input logic [REC_W-1:0]  dbg_history
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (sp_value == RESET_SP && dbg_history == '0 && !mem_we && !mem_re));

  assert_push_access_R2: assert property (@(posedge clk) disable iff (rst)
    (push_req && !sp_load) |=> (mem_we && mem_wdata == $past(push_data)
      && mem_addr == ADDR_W'($past(sp_value) + 1'b1)
      && sp_value == ADDR_W'($past(sp_value) + 1'b1)));

  assert_pop_access_R3: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req && !sp_load) |=> (mem_re && mem_addr == $past(sp_value)
      && sp_value == ADDR_W'($past(sp_value) - 1'b1)));

  assert_push_history_R5: assert property (@(posedge clk) disable iff (rst)
    (push_req && !sp_load) |=>
      (dbg_history == {$past(dbg_history[REC_W-2:0]), $past(push_tag)}));

  assert_pop_history_R6: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req && !sp_load) |=>
      (dbg_history == {1'b0, $past(dbg_history[REC_W-1:1])}));

  assert_load_R7: assert property (@(posedge clk) disable iff (rst)
    sp_load |=> (sp_value == $past(sp_load_val) && $stable(dbg_history)
      && !mem_we && !mem_re));

  assert_push_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop_req && !sp_load) |=> (mem_we && !mem_re));

  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!push_req && !pop_req && !sp_load) |=>
      ($stable(sp_value) && $stable(dbg_history) && !mem_we && !mem_re));

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
endmodule

bind stack_pointer_unit stack_pointer_unit_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REC_W(REC_W), .RESET_SP(RESET_SP)
) u_chk (.*);

// File: tb/test_stack_pointer_unit.sv
`timescale 1ns/1ps
module test_stack_pointer_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       push_req = 1'b0;
  logic [7:0] push_data = '0;
  logic       push_tag = 1'b0;
  logic       pop_req = 1'b0;
  logic       sp_load = 1'b0;
  logic [7:0] sp_load_val = '0;
  logic [7:0] sp_value;
  logic [7:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       mem_we;
  logic       mem_re;
  logic [31:0] dbg_history;

  always #2.5 clk = ~clk;

  stack_pointer_unit i_stack_pointer_unit (
    .clk(clk), .rst(rst), .push_req(push_req), .push_data(push_data),
    .push_tag(push_tag), .pop_req(pop_req), .sp_load(sp_load),
    .sp_load_val(sp_load_val), .sp_value(sp_value), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .dbg_history(dbg_history)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model: integers and a bit queue for the history
  int     m_sp;
  bit     m_hist[$];
  int     m_addr, m_wdata;
  bit     m_we, m_re;
  string  m_tag = "R1";

  function automatic logic [31:0] hist_vec();
    logic [31:0] v = '0;
    for (int i = 0; i < m_hist.size(); i++) v[i] = m_hist[m_hist.size() - 1 - i];
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sp = 7; m_hist.delete(); m_we = 0; m_re = 0; m_tag = "R1";
    end else if (sp_load) begin
      m_sp = sp_load_val; m_we = 0; m_re = 0; m_tag = "R7";
    end else if (push_req) begin
      m_sp = (m_sp + 1) % 256; m_addr = m_sp; m_wdata = push_data;
      m_we = 1; m_re = 0;
      m_hist.push_back(push_tag);
      if (m_hist.size() > 32) void'(m_hist.pop_front());
      m_tag = pop_req ? "R8" : "R5";
    end else if (pop_req) begin
      m_addr = m_sp; m_sp = (m_sp + 255) % 256; m_we = 0; m_re = 1;
      if (m_hist.size() > 0) void'(m_hist.pop_back());
      m_tag = "R6";
    end else begin
      m_we = 0; m_re = 0; m_tag = "R9";
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    string rq_strobe = (m_tag == "R6") ? "R3" : ((m_tag == "R5" || m_tag == "R8") ? "R2" : m_tag);
    check(sp_value == 8'(m_sp), rq_strobe, "sp_value", sp_value, m_sp);
    check(dbg_history == hist_vec(), m_tag, "dbg_history", dbg_history, hist_vec());
    check(mem_we == m_we, (m_tag == "R8") ? "R8" : rq_strobe, "mem_we", mem_we, m_we);
    check(mem_re == m_re, (m_tag == "R8") ? "R8" : rq_strobe, "mem_re", mem_re, m_re);
    check(!(mem_we && mem_re), "R10", "we_and_re", {mem_we, mem_re}, 0);
    if (m_we || m_re) check(mem_addr == 8'(m_addr), rq_strobe, "mem_addr", mem_addr, m_addr);
    if (m_we) check(mem_wdata == 8'(m_wdata), "R2", "mem_wdata", mem_wdata, m_wdata);
  endtask

  task automatic step(bit pu, logic [7:0] d, bit tg, bit po, bit ld, logic [7:0] lv);
    @(negedge clk);
    compare();
    push_req = pu; push_data = d; push_tag = tg; pop_req = po;
    sp_load = ld; sp_load_val = lv;
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    // R1: first push after reset lands at 0x08
    step(1, 8'hA1, 1, 0, 0, 0);
    idle();
    check(mem_addr == 8'h08 && sp_value == 8'h08, "R1", "first_push_addr", mem_addr, 8'h08);
    // R2 / R5: pushes with mixed tags
    for (int i = 0; i < 6; i++) step(1, 8'(8'h10 + i), i[0], 0, 0, 0);
    // R3 / R6: pops
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0);
    idle();
    // R4: wrap on push at 0xFF
    step(0, 0, 0, 0, 1, 8'hFE);
    step(1, 8'h55, 1, 0, 0, 0);
    step(1, 8'h66, 0, 0, 0, 0);
    idle();
    check(sp_value == 8'h00 && mem_addr == 8'h00, "R4", "push_wrap", sp_value, 0);
    // R4: wrap on pop at 0x00
    step(0, 0, 0, 1, 0, 0);
    idle();
    check(sp_value == 8'hFF && mem_addr == 8'h00, "R4", "pop_wrap", sp_value, 8'hFF);
    // R7: load with push and pop requested; history unchanged
    step(1, 8'h77, 1, 1, 1, 8'h40);
    idle();
    check(sp_value == 8'h40 && !mem_we, "R7", "load_priority", sp_value, 8'h40);
    // R8: push and pop together
    step(1, 8'h88, 1, 1, 0, 0);
    idle();
    // R5: overflow the 32-bit history
    for (int i = 0; i < 40; i++) step(1, 8'(i), (i % 3) == 0, 0, 0, 0);
    // R6: drain it, zeros enter at the top
    for (int i = 0; i < 36; i++) step(0, 0, 0, 1, 0, 0);
    idle();
    check(dbg_history == 32'h0, "R6", "drained_history", dbg_history, 0);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 40, 8'($urandom), 1'($urandom), (r >= 30 && r < 75), r >= 95, 8'($urandom));
    end
    // reset in the middle of activity
    step(1, 8'h99, 1, 0, 0, 0);
    @(negedge clk); rst = 1'b1; push_req = 0; pop_req = 0; sp_load = 0;
    @(negedge clk); rst = 1'b0;
    check(sp_value == 8'h07 && dbg_history == 0 && !mem_we && !mem_re, "R1",
          "reset_state", sp_value, 8'h07);
    idle(); idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule